// File: doc/BRIEF.md
# Han-Carlson Parallel-Prefix Adder

This block adds two N-bit unsigned operands and a carry-in in a single combinational pass and returns the N-bit sum and the carry-out. The carries come from a parallel-prefix network. First, each bit forms a generate term and a propagate term. Next, a logarithmic Kogge-Stone style tree runs over the odd bit positions only. Last, one extra level of combining cells fills in the even positions from their odd neighbours. The network has log2(N)+1 levels. No cell drives more than two cells in the level after it. The design accepts one level more logic depth than a full Kogge-Stone tree, and in return uses roughly half as many prefix cells and much less long-range wiring.

The carry-in is merged into the group signals of bit 0 before the tree starts, so the carry into bit i is the group generate of bits i-1 down to 0. Each sum bit is that bit's own propagate XOR the carry into it. The carry-out is the group generate over all N bits. The adder is a drop-in final carry-propagate stage for a multiplier's reduction tree, or a general datapath adder where the delay of a ripple adder is too long.

Top module: `hc_prefix_adder`

## Requirements
- R1: `sum` equals the low N bits of the arithmetic value `a + b + cin` for every combination of inputs.
- R2: `carry_out` equals bit N (the (N+1)-th bit) of the arithmetic value `a + b + cin`.
- R3: When every bit position propagates (`a ^ b` is all ones, for example all-ones plus zero, or alternating 0101… with 1010…), `carry_out` equals `cin`, and `sum` is all ones when `cin` is 0 and all zeros when `cin` is 1.
- R4: With both operands zero, `sum` is `cin` in bit 0 and zero in every other bit, and `carry_out` is 0.
- R5: With both operands all ones, `sum` is all ones in bits N-1 down to 1 with `cin` in bit 0, and `carry_out` is 1.
- R6: Sum bit 0 equals `a[0] ^ b[0] ^ cin`, whatever the other operand bits are.
- R7: The width N is a parameter, default 16. It must be a power of two and at least 2, and any other value stops elaboration. A legal width other than the default (8) also meets R1 and R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Low N bits of a + b + cin |
| carry_out | output | 1 | Carry out of bit N-1 |

## Verification
The block has no state, so a wrong prefix cell or a misrouted span shows at the ports at once, in the same evaluation as the input that exercises it. A broken odd-position cell corrupts several sum bits above it together with the carry-out. A fault in the final even-position level affects a single sum bit. The bench therefore sweeps every input of an 8-bit instance. On the 16-bit instance it drives long propagate chains, full-generate and alternating patterns and random vectors, so that every span of the tree carries a carry that decides some output bit.

// File: rtl/hc_adder_pkg.sv
package hc_adder_pkg;

  // Group signal pair carried through the prefix network.
  typedef struct packed {
    logic g;
    logic p;
  } grp_t;

  // Associative prefix operator: high group absorbs the low group below it.
  function automatic grp_t grp_merge(input grp_t hi, input grp_t lo);
    grp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  function automatic bit is_pow2(input int unsigned v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/hc_pg_gen.sv
module hc_pg_gen #(
  parameter int N = 16
) (
  input  logic [N-1:0] op_x,
  input  logic [N-1:0] op_y,
  output logic [N-1:0] bit_g,
  output logic [N-1:0] bit_p
);

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      assign bit_g[i] = op_x[i] & op_y[i];
      assign bit_p[i] = op_x[i] ^ op_y[i];
    end
  endgenerate

endmodule

// File: rtl/hc_dot_cell.sv
module hc_dot_cell
  import hc_adder_pkg::*;
(
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  input  logic p_lo,
  output logic g_o,
  output logic p_o
);

  grp_t res;

  always_comb begin
    res = grp_merge('{g: g_hi, p: p_hi}, '{g: g_lo, p: p_lo});
  end

  assign g_o = res.g;
  assign p_o = res.p;

endmodule

// File: rtl/hc_prefix_net.sv
module hc_prefix_net #(
  parameter int N = 16
) (
  input  logic [N-1:0] bit_g,
  input  logic [N-1:0] bit_p,
  input  logic         cin,
  output logic [N-1:0] grp_g
);

  localparam int LOG    = $clog2(N);
  localparam int LEVELS = LOG + 1;

  genvar k, i;
  generate
    for (k = 0; k <= LEVELS; k++) begin : lv
      logic [N-1:0] g;
      logic [N-1:0] p;
      if (k == 0) begin : g_seed
        // Fold the carry-in into the group of bit 0.
        assign g[0] = bit_g[0] | (bit_p[0] & cin);
        assign p[0] = bit_p[0];
        if (N > 1) begin : g_rest
          assign g[N-1:1] = bit_g[N-1:1];
          assign p[N-1:1] = bit_p[N-1:1];
        end
      end else begin : g_level
        for (i = 0; i < N; i++) begin : col
          // Span of this level: 1 for the pairing level, doubling on odd
          // positions, then 1 again for the even fill-in level.
          localparam int D = (k == 1 || k == LEVELS) ? 1 : (1 << (k - 1));
          localparam bit ODD_STEP  = (k < LEVELS) && (i % 2 == 1) && (i >= D);
          localparam bit EVEN_STEP = (k == LEVELS) && (i % 2 == 0) && (i >= 2);
          if (ODD_STEP || EVEN_STEP) begin : g_dot
            hc_dot_cell u_dot (
              .g_hi (lv[k-1].g[i]),
              .p_hi (lv[k-1].p[i]),
              .g_lo (lv[k-1].g[i-D]),
              .p_lo (lv[k-1].p[i-D]),
              .g_o  (g[i]),
              .p_o  (p[i])
            );
          end else begin : g_pass
            assign g[i] = lv[k-1].g[i];
            assign p[i] = lv[k-1].p[i];
          end
        end
      end
    end
  endgenerate

  assign grp_g = lv[LEVELS].g;

  // Checks on the finished network against the seed level.
  logic run_p;
  always_comb begin
    run_p = 1'b1;
    for (int j = 0; j < N; j++) begin
      run_p = run_p & lv[0].p[j];
      // R1: each final group propagate is the AND of the seed propagates below it
      a_r1_group_propagate: assert (lv[LEVELS].p[j] == run_p)
        else $error("group propagate wrong at %0d", j);
    end
    if (lv[0].g == '0) begin
      // R4: no seed generate anywhere means no group generate anywhere
      a_r4_no_generate: assert (lv[LEVELS].g == '0)
        else $error("carry appeared without a generate");
    end
    if (lv[0].g == '1) begin
      // R5: every seed generating means every group generates
      a_r5_all_generate: assert (lv[LEVELS].g == '1)
        else $error("group generate missing with full generate");
    end
  end

endmodule

// File: rtl/hc_sum_stage.sv
module hc_sum_stage #(
  parameter int N = 16
) (
  input  logic [N-1:0] bit_p,
  input  logic [N-1:0] grp_g,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         carry_out
);

  logic [N-1:0] carry_in_vec;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_sum
      if (i == 0) begin : g_lsb
        assign carry_in_vec[i] = cin;
      end else begin : g_up
        assign carry_in_vec[i] = grp_g[i-1];
      end
      assign sum[i] = bit_p[i] ^ carry_in_vec[i];
    end
  endgenerate

  assign carry_out = grp_g[N-1];

endmodule

// File: rtl/hc_prefix_adder.sv
module hc_prefix_adder
  import hc_adder_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         carry_out
);

  generate
    if (!is_pow2(N)) begin : g_bad_width
      $error("hc_prefix_adder: N must be a power of two and at least 2 (R7)");
    end
  endgenerate

  logic [N-1:0] bit_g;
  logic [N-1:0] bit_p;
  logic [N-1:0] grp_g;

  hc_pg_gen #(.N(N)) u_pg (
    .op_x  (a),
    .op_y  (b),
    .bit_g (bit_g),
    .bit_p (bit_p)
  );

  hc_prefix_net #(.N(N)) u_net (
    .bit_g (bit_g),
    .bit_p (bit_p),
    .cin   (cin),
    .grp_g (grp_g)
  );

  hc_sum_stage #(.N(N)) u_sum (
    .bit_p     (bit_p),
    .grp_g     (grp_g),
    .cin       (cin),
    .sum       (sum),
    .carry_out (carry_out)
  );

  // Port-level checks against plain arithmetic.
  logic [N:0] ref_total;
  always_comb begin
    ref_total = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};
    a_r1_sum_value: assert (sum == ref_total[N-1:0])
      else $error("sum mismatch");
    a_r2_carry_out: assert (carry_out == ref_total[N])
      else $error("carry-out mismatch");
    a_r6_lsb: assert (sum[0] == (a[0] ^ b[0] ^ cin))
      else $error("bit 0 sum mismatch");
    if ((a ^ b) == '1) begin
      a_r3_full_propagate: assert ((carry_out == cin) && (sum == (cin ? '0 : '1)))
        else $error("full propagate chain wrong");
    end
  end

endmodule

// File: tb/sim_hc_prefix_adder.sv
module sim_hc_prefix_adder;

  localparam int CLK_PERIOD = 10;
  localparam int WIDE = 16;
  localparam int SMALL = 8;
  localparam int WATCHDOG_CYCLES = 190000;
  localparam int RANDOM_VECTORS = 12000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [WIDE-1:0]  w_a, w_b, w_sum;
  logic             w_cin, w_co;
  logic [SMALL-1:0] s_a, s_b, s_sum;
  logic             s_cin, s_co;

  hc_prefix_adder #(.N(WIDE)) u0 (
    .a (w_a), .b (w_b), .cin (w_cin), .sum (w_sum), .carry_out (w_co)
  );

  hc_prefix_adder #(.N(SMALL)) u1 (
    .a (s_a), .b (s_b), .cin (s_cin), .sum (s_sum), .carry_out (s_co)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG_CYCLES && !done) begin
      done = 1'b1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d",
               cycles, WATCHDOG_CYCLES);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  // Drive the wide instance away from the clock edge and compare against
  // an explicit expected sum and carry-out.
  task automatic apply_wide(input logic [WIDE-1:0] x, input logic [WIDE-1:0] y,
                            input logic c, input logic [WIDE-1:0] exp_s,
                            input logic exp_c, input string req);
    @(negedge clk);
    w_a = x; w_b = y; w_cin = c;
    #2;
    checks++;
    if (w_sum !== exp_s || w_co !== exp_c) begin
      fails++;
      $display("FAIL %s: a=%h b=%h cin=%b actual sum=%h co=%b expected sum=%h co=%b",
               req, x, y, c, w_sum, w_co, exp_s, exp_c);
    end
  endtask

  // Expected value from plain arithmetic (R1 and R2).
  task automatic arith_wide(input logic [WIDE-1:0] x, input logic [WIDE-1:0] y,
                            input logic c, input string req);
    logic [WIDE:0] t;
    t = {1'b0, x} + {1'b0, y} + {{WIDE{1'b0}}, c};
    apply_wide(x, y, c, t[WIDE-1:0], t[WIDE], req);
  endtask

  initial begin
    w_a = '0; w_b = '0; w_cin = 1'b0;
    s_a = '0; s_b = '0; s_cin = 1'b0;

    // R4: zero operands, both carry-in values
    apply_wide('0, '0, 1'b0, 16'h0000, 1'b0, "R4 zero operands cin=0");
    apply_wide('0, '0, 1'b1, 16'h0001, 1'b0, "R4 zero operands cin=1");

    // R3: all-ones plus one and other full propagate chains
    apply_wide('1, '0, 1'b1, 16'h0000, 1'b1, "R3 all-ones plus carry-in");
    apply_wide('0, '1, 1'b1, 16'h0000, 1'b1, "R3 zero plus all-ones plus carry-in");
    apply_wide('1, '0, 1'b0, 16'hFFFF, 1'b0, "R3 all-ones no carry-in");
    apply_wide(16'h5555, 16'hAAAA, 1'b0, 16'hFFFF, 1'b0, "R3 alternating cin=0");
    apply_wide(16'h5555, 16'hAAAA, 1'b1, 16'h0000, 1'b1, "R3 alternating cin=1");
    apply_wide(16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1, "R3 alternating swapped");

    // R5: full generate
    apply_wide('1, '1, 1'b0, 16'hFFFE, 1'b1, "R5 all-ones both cin=0");
    apply_wide('1, '1, 1'b1, 16'hFFFF, 1'b1, "R5 all-ones both cin=1");

    // R1/R2: alternating same-phase patterns and single-carry spans
    arith_wide(16'h5555, 16'h5555, 1'b1, "R1 R2 alternating same phase");
    arith_wide(16'hAAAA, 16'hAAAA, 1'b0, "R1 R2 alternating high phase");
    for (int s = 0; s < WIDE; s++) begin
      // a run of propagates above a single generate at bit s
      arith_wide(16'hFFFF << s, 16'h0001 << s, 1'b0, "R1 R2 generate then propagate run");
      arith_wide(16'hFFFF >> s, 16'h0000, 1'b1, "R1 R2 carry-in through run");
    end

    // R6: bit 0 alone decides sum[0]
    for (int v = 0; v < 8; v++) begin
      logic x0, y0, c0;
      logic [WIDE:0] t;
      x0 = v[0]; y0 = v[1]; c0 = v[2];
      @(negedge clk);
      w_a = {$urandom()} [WIDE-1:0]; w_b = {$urandom()} [WIDE-1:0];
      w_a[0] = x0; w_b[0] = y0; w_cin = c0;
      #2;
      checks++;
      t = {1'b0, w_a} + {1'b0, w_b} + {{WIDE{1'b0}}, w_cin};
      if (w_sum[0] !== (x0 ^ y0 ^ c0) || w_sum !== t[WIDE-1:0]) begin
        fails++;
        $display("FAIL R6: actual sum=%h expected sum=%h (bit0 %b)",
                 w_sum, t[WIDE-1:0], x0 ^ y0 ^ c0);
      end
    end

    // R1/R2: random vectors on the 16-bit instance
    for (int r = 0; r < RANDOM_VECTORS; r++) begin
      arith_wide($urandom(), $urandom(), $urandom() % 2 == 1, "R1 R2 random");
    end

    // R7: exhaustive sweep of the 8-bit instance
    for (int x = 0; x < (1 << SMALL); x++) begin
      for (int y = 0; y < (1 << SMALL); y++) begin
        for (int c = 0; c < 2; c++) begin
          int total;
          @(negedge clk);
          s_a = x[SMALL-1:0]; s_b = y[SMALL-1:0]; s_cin = c[0];
          #2;
          total = x + y + c;
          checks++;
          if (s_sum !== total[SMALL-1:0] || s_co !== total[SMALL]) begin
            fails++;
            $display("FAIL R7 8-bit: a=%h b=%h cin=%0d actual sum=%h co=%b expected sum=%h co=%b",
                     x[SMALL-1:0], y[SMALL-1:0], c, s_sum, s_co,
                     total[SMALL-1:0], total[SMALL]);
          end
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule